// File: doc/BRIEF.md
# Dual Page Buffer Write Sequencer

This block receives a serial command stream that has already been assembled into bytes and stores the payload in one of two on-chip page buffers. The first byte of each transaction is an opcode that picks the target buffer. The next three bytes form a 24-bit address, sent most significant byte first. Only the low bits of this address give the starting byte within the buffer. Every byte after that is written at the current position, and the position then advances. When it passes the last byte of the page it returns to byte 0. The transaction ends when the chip-select-high pulse arrives.

The page length is set by a static mode input. In long mode a page holds 528 bytes, which is not a power of two. In short mode it holds 512 bytes. The mode sets how many address bits are used and where the write position wraps. The mode is only changed between commands. The two buffers are internal arrays. An asynchronous read-back port lets surrounding logic, or a bench, inspect any stored byte.

Top module: `pgbuf_writer`

## Requirements
- R1: A first byte of 0x84 selects buffer 0 and a first byte of 0x87 selects buffer 1 (read-back select 0 and 1). Only the selected buffer is written.
- R2: The address is 24 bits: the first address byte is bits 23..16 and the third is bits 7..0. In long mode (long_page=1) the start position is bits 9..0. In short mode it is bits 8..0. All higher bits are ignored.
- R3: The first data byte comes right after the third address byte, with no dummy byte. Each later data byte is written one position higher.
- R4: After a write at the last position (527 in long mode, 511 in short mode) the next write goes to position 0. In short mode, positions 512..527 are never written.
- R5: A cs_end pulse ends the command. A byte presented in the same cycle as cs_end is discarded. Bytes without byte_first after the end are ignored.
- R6: Any other first-byte value writes nothing for the rest of that transaction.
- R7: A long-mode start position above 527 (528..1023) is replaced by position 0.
- R8: A byte with byte_first always starts a new command, even in the middle of a transaction. Bytes without byte_first are ignored until a command has started.
- R9: Reset returns the sequencer to idle and leaves buffer contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| long_page | input | 1 | Page mode: 1 means 528 bytes, 0 means 512 bytes |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_first | input | 1 | The present byte is the first after chip select fell |
| byte_data | input | 8 | Received byte |
| cs_end | input | 1 | One-cycle pulse: chip select went high |
| rd_sel | input | 1 | Read-back buffer select |
| rd_addr | input | 10 | Read-back byte position |
| rd_data | output | 8 | Stored byte at rd_sel/rd_addr (0 beyond the buffer) |

## Verification
The bench first fills both buffers completely in long mode, so every later scan compares all 1056 stored bytes with a reference the bench computes itself. A sweep of start positions around 0, 255 and the two page ends, run in both modes, separates correct masking and wrapping from an off-by-one or from a wrap that ignores the mode. Starting at 520 with junk in the upper address bits tests bit extraction and the wrap together. Full-page runs show that no position is written twice within one pass. Negative patterns include a wrong opcode, stray bytes after the end, a byte that coincides with the end pulse, a restart in the middle of a transaction, and a reset in the middle of data. In each case the untouched neighbours must stay unchanged.

// File: rtl/pgbuf_pkg.sv
`timescale 1ns/1ps
package pgbuf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR_HI,
    ST_ADR_MID,
    ST_ADR_LO,
    ST_DATA,
    ST_SKIP
  } seq_st_t;

  // start position: keep nbits low bits, fold anything past the page end to 0
  function automatic int unsigned start_pos(input logic [23:0] raw,
                                            input int unsigned nbits,
                                            input int unsigned last);
    int unsigned m;
    m = 32'(raw) & ((32'd1 << nbits) - 32'd1);
    return (m > last) ? 32'd0 : m;
  endfunction

  // advance with wrap at the last byte of the page
  function automatic int unsigned step_pos(input int unsigned pos,
                                           input int unsigned last);
    return (pos >= last) ? 32'd0 : pos + 32'd1;
  endfunction

endpackage

// File: rtl/pgbuf_decode.sv
`timescale 1ns/1ps
module pgbuf_decode #(
  parameter logic [7:0] OP_BANK0 = 8'h84,
  parameter logic [7:0] OP_BANK1 = 8'h87
) (
  input  logic [7:0] opcode,
  output logic       op_hit,
  output logic       op_bank
);
  always_comb begin
    op_hit  = (opcode == OP_BANK0) || (opcode == OP_BANK1);
    op_bank = (opcode == OP_BANK1);
  end
endmodule

// File: rtl/pgbuf_seq.sv
`timescale 1ns/1ps
module pgbuf_seq #(
  parameter int unsigned DEPTH_LONG  = 528,
  parameter int unsigned DEPTH_SHORT = 512,
  localparam int unsigned AW    = $clog2(DEPTH_LONG),
  localparam int unsigned BITS_L = $clog2(DEPTH_LONG),
  localparam int unsigned BITS_S = $clog2(DEPTH_SHORT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          long_page,
  input  logic          byte_vld,
  input  logic          byte_first,
  input  logic [7:0]    byte_data,
  input  logic          cs_end,
  input  logic          op_hit,
  input  logic          op_bank,
  output logic          wr_fire,
  output logic          wr_bank,
  output logic [AW-1:0] wr_ptr
);
  import pgbuf_pkg::*;

  seq_st_t      state;
  logic [15:0]  adr_hi;
  int unsigned  last_i;
  int unsigned  nbits_i;
  logic [AW-1:0] last_idx;

  always_comb begin
    last_i   = long_page ? (DEPTH_LONG - 1) : (DEPTH_SHORT - 1);
    nbits_i  = long_page ? BITS_L : BITS_S;
    last_idx = AW'(last_i);
    wr_fire  = byte_vld && !byte_first && !cs_end && (state == ST_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      adr_hi  <= '0;
      wr_bank <= 1'b0;
      wr_ptr  <= '0;
    end else if (cs_end) begin
      state <= ST_IDLE;
    end else if (byte_vld && byte_first) begin
      state   <= op_hit ? ST_ADR_HI : ST_SKIP;
      wr_bank <= op_bank;
    end else if (byte_vld) begin
      unique case (state)
        ST_ADR_HI: begin
          adr_hi[15:8] <= byte_data;
          state        <= ST_ADR_MID;
        end
        ST_ADR_MID: begin
          adr_hi[7:0] <= byte_data;
          state       <= ST_ADR_LO;
        end
        ST_ADR_LO: begin
          wr_ptr <= AW'(start_pos({adr_hi, byte_data}, nbits_i, last_i));
          state  <= ST_DATA;
        end
        ST_DATA:  wr_ptr <= AW'(step_pos(32'(wr_ptr), last_i));
        default:  state <= state;
      endcase
    end
  end

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_ptr == last_idx) |=> (wr_ptr == '0));

  assert_incr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_ptr != last_idx) |=> (wr_ptr == $past(wr_ptr) + AW'(1)));

  assert_in_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (wr_ptr <= last_idx));

  assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> !wr_fire);

  assert_badop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_first && !cs_end && !op_hit) |=> (state == ST_SKIP));
endmodule

// File: rtl/pgbuf_ram.sv
`timescale 1ns/1ps
module pgbuf_ram #(
  parameter int unsigned NBANK = 2,
  parameter int unsigned DEPTH = 528,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned SW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] we_sel,
  input  logic [AW-1:0] we_addr,
  input  logic [7:0]    we_data,
  input  logic [SW-1:0] rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [NBANK-1:0] we_vec;
  logic [7:0]       rd_vec [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [7:0] mem [DEPTH];
    assign we_vec[g] = we && (we_sel == SW'(g));
    always_ff @(posedge clk) begin
      if (we_vec[g]) mem[we_addr] <= we_data;
    end
    assign rd_vec[g] = (32'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;
  end

  assign rd_data = rd_vec[rd_sel];

  assert_one_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));
endmodule

// File: rtl/pgbuf_writer.sv
`timescale 1ns/1ps
module pgbuf_writer #(
  parameter int unsigned DEPTH_LONG  = 528,
  parameter int unsigned DEPTH_SHORT = 512,
  parameter logic [7:0]  OP_BANK0    = 8'h84,
  parameter logic [7:0]  OP_BANK1    = 8'h87,
  localparam int unsigned AW = $clog2(DEPTH_LONG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          long_page,
  input  logic          byte_vld,
  input  logic          byte_first,
  input  logic [7:0]    byte_data,
  input  logic          cs_end,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic          op_hit;
  logic          op_bank;
  logic          wr_fire;
  logic          wr_bank;
  logic [AW-1:0] wr_ptr;

  pgbuf_decode #(.OP_BANK0(OP_BANK0), .OP_BANK1(OP_BANK1)) u_dec (
    .opcode (byte_data),
    .op_hit (op_hit),
    .op_bank(op_bank)
  );

  pgbuf_seq #(.DEPTH_LONG(DEPTH_LONG), .DEPTH_SHORT(DEPTH_SHORT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .long_page (long_page),
    .byte_vld  (byte_vld),
    .byte_first(byte_first),
    .byte_data (byte_data),
    .cs_end    (cs_end),
    .op_hit    (op_hit),
    .op_bank   (op_bank),
    .wr_fire   (wr_fire),
    .wr_bank   (wr_bank),
    .wr_ptr    (wr_ptr)
  );

  pgbuf_ram #(.NBANK(2), .DEPTH(DEPTH_LONG)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_fire),
    .we_sel (wr_bank),
    .we_addr(wr_ptr),
    .we_data(byte_data),
    .rd_sel (rd_sel),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );
endmodule

// File: tb/pgbuf_writer_tb.sv
`timescale 1ns/1ps
module pgbuf_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DL = 528;
  localparam int DS = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       long_page = 1'b1;
  logic       byte_vld = 1'b0;
  logic       byte_first = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       cs_end = 1'b0;
  logic       rd_sel = 1'b0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [7:0] ref_m [2][DL];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgbuf_writer u_dut (
    .clk(clk), .rst_n(rst_n), .long_page(long_page),
    .byte_vld(byte_vld), .byte_first(byte_first), .byte_data(byte_data),
    .cs_end(cs_end), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 29 + k * 11 + 3) & 255);
  endfunction

  task automatic send(logic [7:0] b, logic first, logic endp);
    @(negedge clk);
    byte_vld = 1'b1; byte_first = first; byte_data = b; cs_end = endp;
    @(negedge clk);
    byte_vld = 1'b0; byte_first = 1'b0; cs_end = 1'b0;
  endtask

  task automatic end_cs();
    @(negedge clk); cs_end = 1'b1;
    @(negedge clk); cs_end = 1'b0;
  endtask

  // a command; the bench model updates ref_m by its own arithmetic
  task automatic cmd(logic [7:0] op, logic [23:0] adr, int n, int seed, logic fin);
    int bank, last, mask, p;
    send(op, 1'b1, 1'b0);
    send(adr[23:16], 1'b0, 1'b0);
    send(adr[15:8], 1'b0, 1'b0);
    send(adr[7:0], 1'b0, 1'b0);
    for (int k = 0; k < n; k++) send(pat(seed, k), 1'b0, 1'b0);
    if (fin) end_cs();
    if (op == 8'h84 || op == 8'h87) begin
      bank = (op == 8'h87) ? 1 : 0;
      last = long_page ? DL - 1 : DS - 1;
      mask = long_page ? 1023 : 511;
      p = int'(adr) & mask;
      if (p > last) p = 0;
      for (int k = 0; k < n; k++) begin
        ref_m[bank][p] = pat(seed, k);
        p = (p == last) ? 0 : p + 1;
      end
    end
  endtask

  task automatic scan(string tag);
    int miss = 0;
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < DL; a++) begin
        rd_sel = b[0]; rd_addr = 10'(a);
        #1;
        if (rd_data !== ref_m[b][a]) begin
          if (miss == 0)
            $display("FAIL %s buf%0d[%0d] got=%02h exp=%02h", tag, b, a, rd_data, ref_m[b][a]);
          miss++;
        end
      end
    end
    total++;
    if (miss != 0) bad++;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int starts [7] = '{0, 1, 255, 510, 511, 526, 527};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: bytes before any first flag write nothing (contents unknown, so prefill after)
    send(8'hAA, 1'b0, 1'b0);
    // R1, R3: full fill of both buffers from position 0, long mode
    long_page = 1'b1;
    cmd(8'h84, 24'h000000, DL, 1, 1'b1);
    cmd(8'h87, 24'h000000, DL, 2, 1'b1);
    scan("R1_R3_fill");
    // R4: long wrap with junk high bits, buffer 1
    cmd(8'h87, 24'hABFC00 | 24'd520, 20, 3, 1'b1);
    scan("R4_R2_long_wrap");
    // R2: short mode masks bits 23..9
    long_page = 1'b0;
    cmd(8'h84, 24'hFFFE05, 6, 4, 1'b1);
    scan("R2_short_mask");
    // R4: short wrap at 511, 512..527 untouched
    cmd(8'h84, 24'h0001F9, 25, 5, 1'b1);
    scan("R4_short_wrap");
    // R4: full short page plus extra
    cmd(8'h87, 24'h000100, DS + 7, 6, 1'b1);
    scan("R4_short_full");
    // R7: start above last in long mode folds to 0
    long_page = 1'b1;
    cmd(8'h84, 24'h000384, 4, 7, 1'b1);
    scan("R7_fold");
    // R6: unknown opcode writes nothing
    cmd(8'h83, 24'h000010, 8, 8, 1'b1);
    cmd(8'h00, 24'h000020, 8, 9, 1'b1);
    scan("R6_badop");
    // R5: stray bytes after the end pulse, and a byte coinciding with it
    cmd(8'h87, 24'h000040, 3, 10, 1'b0);
    send(8'h5A, 1'b0, 1'b1);
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b0);
    scan("R5_end");
    // R8: restart in the middle of data
    cmd(8'h84, 24'h000080, 5, 11, 1'b0);
    cmd(8'h87, 24'h000090, 5, 12, 1'b1);
    scan("R8_restart");
    // R9: reset during data keeps contents, sequencer idle afterwards
    cmd(8'h84, 24'h0000A0, 4, 13, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    send(8'h33, 1'b0, 1'b0);
    send(8'h44, 1'b0, 1'b0);
    end_cs();
    scan("R9_reset");
    // R2, R3, R4: start sweep around page edges, both modes and both buffers
    for (int m = 0; m < 2; m++) begin
      long_page = m[0];
      foreach (starts[i]) begin
        cmd((i % 2 == 0) ? 8'h84 : 8'h87, 24'h3C0000 | 24'(starts[i]), 3, 20 + i + 7 * m, 1'b1);
      end
      scan(m == 0 ? "R4_sweep_short" : "R4_sweep_long");
    end
    // R4: full long page plus wrap
    long_page = 1'b1;
    cmd(8'h87, 24'h000007, DL + 3, 40, 1'b1);
    scan("R4_long_full");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule